// File: doc/BRIEF.md
# Serial Channel Control and Status Register Block

This block holds the software-visible configuration and status for one serial channel, which can run as a UART or as an SPI master or slave. Software reaches it over a simple byte-wide bus with an address, a write strobe, a read strobe and write and read data. The block has three locations: a mode/status byte, a UART framing control byte, and a receive data buffer window. The serial shift engines, the baud-rate generator and the SPI datapath sit outside the block. They report events (framing error, parity error, byte received, transmit finished) and a busy level. In return they get their configuration and a flush pulse.

Each status flag clears in its own way. The two error flags clear when the status byte is read. The receive-ready flag clears when the data buffer is read. Writing 0 to the receive-ready flag also drops the buffered byte. The transmit-done flag clears only when software writes 0 to it. The busy bit cannot be written, and the flush bit clears itself. A hardware event always beats a software clear that lands in the same cycle. A read that clears a flag still returns the flag as set.

Top module: `ser_ctl_regs`

## Requirements
- R1: After reset the status byte (address 0) reads 0x00 when the busy sources are low. The UART control byte (address 1) reads 0x02, so the stop level output is high.
- R2: Read data is registered. `bus_rdata` updates on the clock edge where `bus_rd` is high and holds its value until the next read. Address 2 returns `rx_data`, and address 3 reads 0x00.
- R3: Writes to status bits 7 (UART mode = 1, SPI = 0), 6 (receiver enable) and 5 (SPI slave = 1) read back as written. Writes to UART control bits 6..0 also read back as written.
- R4: Status bit 4 (framing error) and bit 3 (parity error) are set by their event inputs. A read of address 0 clears both, and that read still returns them as 1. Reading address 0 does not clear status bits 2 or 1.
- R5: Writing 0 to status bit 4, 3, 2 or 1 clears that flag. Writing 1 to any of these bits leaves the flag unchanged.
- R6: Status bit 2 (receive ready) is set by `ev_rx_byte` and cleared by a read of address 2.
- R7: A write to address 0 with bit 2 = 0 while receive ready is set, and with no new byte arriving in that cycle, raises `rx_discard` for exactly one cycle after the write edge.
- R8: If a hardware set event and a clear (by read or by write of 0) hit the same flag in the same cycle, the flag ends up set. Status bit 1 (transmit done) is set by `ev_tx_done`.
- R9: Status bit 0 (busy) ignores writes. It shows `ssel_in` when bit 7 = 0 and bit 5 = 1 (SPI slave), and `engine_busy` otherwise.
- R10: UART control bit 7 (flush) always reads 0. Writing it as 1 gives a `flush_pulse` that is high for exactly the one cycle after the write edge.
- R11: The configuration outputs follow the register fields. Status bits 7..5 drive `cfg_uart_mode`, `cfg_rx_en` and `cfg_spi_slave`. UART control bits 6..0 drive `cfg_flow_en`, `cfg_bit9_val`, `cfg_bit9_en`, `cfg_parity_en`, `cfg_two_stop`, `cfg_stop_lvl` and `cfg_start_lvl`, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Received byte held by the receive engine |
| ev_frame_err | input | 1 | Pulse: byte received with a bad stop level |
| ev_parity_err | input | 1 | Pulse: byte received with a parity error |
| ev_rx_byte | input | 1 | Pulse: a received byte is ready |
| ev_tx_done | input | 1 | Pulse: the last written byte has been sent |
| engine_busy | input | 1 | Transmit or receive in progress |
| ssel_in | input | 1 | Slave-select level, as used in SPI slave mode |
| cfg_uart_mode | output | 1 | 1 = UART, 0 = SPI |
| cfg_rx_en | output | 1 | Receiver enable |
| cfg_spi_slave | output | 1 | 1 = SPI slave, 0 = SPI master |
| cfg_flow_en | output | 1 | Hardware flow control enable |
| cfg_bit9_val | output | 1 | Ninth bit value / parity sense (1 = even) |
| cfg_bit9_en | output | 1 | Ninth bit transfer enable |
| cfg_parity_en | output | 1 | Parity enable |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_stop_lvl | output | 1 | Stop bit level |
| cfg_start_lvl | output | 1 | Start bit level |
| flush_pulse | output | 1 | One-cycle abort to the serial engines |
| rx_discard | output | 1 | One-cycle pulse: buffered byte dropped |

## Verification
The register state, the configuration outputs, `flush_pulse` and `rx_discard` all change at the edge that takes the write or event. Read data becomes valid on the edge that takes `bus_rd`. The bench drives each strobe from one falling edge to the next and samples at the following falling edge, which is exactly one register stage after the stimulus. Same-cycle collisions are built by raising an event and a read or write strobe on the same falling edge. The pulse outputs are then sampled once more on the falling edge after that, to confirm they last a single cycle.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

    localparam int DATA_W = 8;
    localparam int NFLAGS = 4;

    // flag vector order (index): 3 frame error, 2 parity error, 1 rx ready, 0 tx done
    typedef struct packed {
        logic frame_err;
        logic par_err;
        logic rx_rdy;
        logic tx_done;
    } flags_t;

    typedef struct packed {
        logic uart;
        logic rx_en;
        logic slave;
    } mode_t;

    typedef struct packed {
        logic flow;
        logic b9_val;
        logic b9_en;
        logic par_en;
        logic two_stop;
        logic stop_lvl;
        logic start_lvl;
    } uctl_t;

    localparam mode_t MODE_RST = '0;
    localparam uctl_t UCTL_RST = 7'b000_0010;

    // which flags a status read or a buffer read clears
    localparam logic [NFLAGS-1:0] CLR_ON_STAT_RD = 4'b1100;
    localparam logic [NFLAGS-1:0] CLR_ON_DBUF_RD = 4'b0010;
    localparam int RX_FLAG_IDX = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_UCTL = 2'd2,
        SEL_DBUF = 2'd3
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] stat_byte(mode_t m, flags_t f, logic busy);
        return {m, f, busy};
    endfunction

    function automatic logic [DATA_W-1:0] uctl_byte(uctl_t u);
        return {1'b0, u};
    endfunction

    function automatic logic busy_view(mode_t m, logic eng_busy, logic ssel);
        return (!m.uart && m.slave) ? ssel : eng_busy;
    endfunction

endpackage

// File: rtl/ser_addr_dec.sv
module ser_addr_dec
    import ser_ctl_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int UCTL_ADDR = 1,
    parameter int DBUF_ADDR = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(STAT_ADDR))      sel = SEL_STAT;
        else if (addr == ADDR_W'(UCTL_ADDR)) sel = SEL_UCTL;
        else if (addr == ADDR_W'(DBUF_ADDR)) sel = SEL_DBUF;
        else                                 sel = SEL_NONE;
    end
endmodule

// File: rtl/ser_flag_bank.sv
module ser_flag_bank
    import ser_ctl_pkg::*;
#(
    parameter int                N          = NFLAGS,
    parameter logic [N-1:0]      STAT_CLR   = CLR_ON_STAT_RD,
    parameter logic [N-1:0]      DBUF_CLR   = CLR_ON_DBUF_RD,
    parameter int                DISC_IDX   = RX_FLAG_IDX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         wr_stat,
    input  logic [N-1:0] wr_bits,
    input  logic         rd_stat,
    input  logic         rd_dbuf,
    output logic [N-1:0] flag_q,
    output logic         discard
);
    logic [N-1:0] clr;

    for (genvar i = 0; i < N; i++) begin : g_flag
        assign clr[i] = (wr_stat && !wr_bits[i])
                      || (rd_stat && STAT_CLR[i])
                      || (rd_dbuf && DBUF_CLR[i]);

        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= set_ev[i] || (flag_q[i] && !clr[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) discard <= 1'b0;
        else     discard <= wr_stat && !wr_bits[DISC_IDX]
                            && flag_q[DISC_IDX] && !set_ev[DISC_IDX];
    end
endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
    import ser_ctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stat,
    input  logic         wr_uctl,
    input  logic [W-1:0] wdata,
    output mode_t        mode_q,
    output uctl_t        uctl_q,
    output logic         flush_q
);
    localparam int MODE_LSB = W - $bits(mode_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RST;
            uctl_q  <= UCTL_RST;
            flush_q <= 1'b0;
        end else begin
            if (wr_stat) mode_q <= mode_t'(wdata[W-1:MODE_LSB]);
            if (wr_uctl) uctl_q <= uctl_t'(wdata[$bits(uctl_t)-1:0]);
            flush_q <= wr_uctl && wdata[W-1];
        end
    end
endmodule

// File: rtl/ser_rd_port.sv
module ser_rd_port
    import ser_ctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd,
    input  reg_sel_e     sel,
    input  mode_t        mode_q,
    input  flags_t       flags,
    input  uctl_t        uctl_q,
    input  logic         eng_busy,
    input  logic         ssel,
    input  logic [W-1:0] rx_data,
    output logic [W-1:0] rdata
);
    logic [W-1:0] mux;

    always_comb begin
        unique case (sel)
            SEL_STAT: mux = stat_byte(mode_q, flags, busy_view(mode_q, eng_busy, ssel));
            SEL_UCTL: mux = uctl_byte(uctl_q);
            SEL_DBUF: mux = rx_data;
            default:  mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= mux;
    end
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
    import ser_ctl_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int UCTL_ADDR = 1,
    parameter int DBUF_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        rx_data,
    input  logic              ev_frame_err,
    input  logic              ev_parity_err,
    input  logic              ev_rx_byte,
    input  logic              ev_tx_done,
    input  logic              engine_busy,
    input  logic              ssel_in,
    output logic              cfg_uart_mode,
    output logic              cfg_rx_en,
    output logic              cfg_spi_slave,
    output logic              cfg_flow_en,
    output logic              cfg_bit9_val,
    output logic              cfg_bit9_en,
    output logic              cfg_parity_en,
    output logic              cfg_two_stop,
    output logic              cfg_stop_lvl,
    output logic              cfg_start_lvl,
    output logic              flush_pulse,
    output logic              rx_discard
);
    reg_sel_e            sel;
    logic                wr_stat, wr_uctl, rd_stat, rd_dbuf;
    logic [NFLAGS-1:0]   flag_q;
    flags_t              flags;
    flags_t              set_ev;
    mode_t               mode_q;
    uctl_t               uctl_q;

    ser_addr_dec #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
        .UCTL_ADDR(UCTL_ADDR), .DBUF_ADDR(DBUF_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    assign wr_stat = bus_wr && (sel == SEL_STAT);
    assign wr_uctl = bus_wr && (sel == SEL_UCTL);
    assign rd_stat = bus_rd && (sel == SEL_STAT);
    assign rd_dbuf = bus_rd && (sel == SEL_DBUF);

    assign set_ev = '{frame_err: ev_frame_err, par_err: ev_parity_err,
                      rx_rdy: ev_rx_byte, tx_done: ev_tx_done};

    ser_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_ev (set_ev),
        .wr_stat(wr_stat),
        .wr_bits(bus_wdata[NFLAGS:1]),
        .rd_stat(rd_stat),
        .rd_dbuf(rd_dbuf),
        .flag_q (flag_q),
        .discard(rx_discard)
    );

    assign flags = flags_t'(flag_q);

    ser_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_stat(wr_stat),
        .wr_uctl(wr_uctl),
        .wdata  (bus_wdata),
        .mode_q (mode_q),
        .uctl_q (uctl_q),
        .flush_q(flush_pulse)
    );

    ser_rd_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (bus_rd),
        .sel     (sel),
        .mode_q  (mode_q),
        .flags   (flags),
        .uctl_q  (uctl_q),
        .eng_busy(engine_busy),
        .ssel    (ssel_in),
        .rx_data (rx_data),
        .rdata   (bus_rdata)
    );

    assign cfg_uart_mode = mode_q.uart;
    assign cfg_rx_en     = mode_q.rx_en;
    assign cfg_spi_slave = mode_q.slave;
    assign cfg_flow_en   = uctl_q.flow;
    assign cfg_bit9_val  = uctl_q.b9_val;
    assign cfg_bit9_en   = uctl_q.b9_en;
    assign cfg_parity_en = uctl_q.par_en;
    assign cfg_two_stop  = uctl_q.two_stop;
    assign cfg_stop_lvl  = uctl_q.stop_lvl;
    assign cfg_start_lvl = uctl_q.start_lvl;
endmodule

// File: rtl/ser_ctl_chk.sv
module ser_ctl_chk #(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int UCTL_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              ev_frame_err,
    input logic              ev_parity_err,
    input logic              cfg_uart_mode,
    input logic              flush_pulse,
    input logic              rx_discard,
    input logic [3:0]        flag_q
);
    logic stat_wr, uctl_wr;
    assign stat_wr = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));
    assign uctl_wr = bus_wr && (bus_addr == ADDR_W'(UCTL_ADDR));

    a_r10_flush_from_write: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |-> $past(uctl_wr && bus_wdata[7]));

    a_r7_discard_from_write: assert property (@(posedge clk) disable iff (rst)
        rx_discard |-> $past(stat_wr && !bus_wdata[2]));

    a_r8_frame_set_wins: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ev_frame_err)) |-> flag_q[3]);

    a_r8_parity_set_wins: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ev_parity_err)) |-> flag_q[2]);

    a_r5_no_set_by_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ev_frame_err)) |-> !$rose(flag_q[3]));

    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_rd)) |-> $stable(bus_rdata));

    a_r11_mode_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stat_wr)) |-> $stable(cfg_uart_mode));
endmodule

bind ser_ctl_regs ser_ctl_chk #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .UCTL_ADDR(UCTL_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ev_frame_err (ev_frame_err),
    .ev_parity_err(ev_parity_err),
    .cfg_uart_mode(cfg_uart_mode),
    .flush_pulse  (flush_pulse),
    .rx_discard   (rx_discard),
    .flag_q       (flag_q)
);

// File: tb/sim_ser_ctl_regs.sv
module sim_ser_ctl_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, rx_data = '0;
    logic       ev_frame_err = 0, ev_parity_err = 0, ev_rx_byte = 0, ev_tx_done = 0;
    logic       engine_busy = 0, ssel_in = 0;
    logic       cfg_uart_mode, cfg_rx_en, cfg_spi_slave, cfg_flow_en, cfg_bit9_val;
    logic       cfg_bit9_en, cfg_parity_en, cfg_two_stop, cfg_stop_lvl, cfg_start_lvl;
    logic       flush_pulse, rx_discard;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ser_ctl_regs u0 (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    // sel: 3 frame, 2 parity, 1 rx, 0 tx
    task automatic pulse(input logic [3:0] sel);
        @(negedge clk);
        {ev_frame_err, ev_parity_err, ev_rx_byte, ev_tx_done} = sel;
        @(negedge clk);
        {ev_frame_err, ev_parity_err, ev_rx_byte, ev_tx_done} = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 status reset", 2'd0, 8'h00);
        rd_chk("R1 uctl reset", 2'd1, 8'h02);
        chk("R1 stop level", {7'd0, cfg_stop_lvl}, 8'h01);
        chk("R1 flush idle", {7'd0, flush_pulse}, 8'h00);

        // R2 read data holds between reads
        repeat (3) @(negedge clk);
        chk("R2 rdata hold", bus_rdata, 8'h02);
        rd_chk("R2 unmapped addr", 2'd3, 8'h00);

        // R3 R10 R11 sweep of the UART control byte
        for (int v = 0; v < 256; v++) begin
            wr(2'd1, 8'(v));
            chk("R10 flush pulse on write", {7'd0, flush_pulse}, {7'd0, v[7]});
            chk("R11 uctl outputs",
                {1'b0, cfg_flow_en, cfg_bit9_val, cfg_bit9_en, cfg_parity_en,
                 cfg_two_stop, cfg_stop_lvl, cfg_start_lvl}, {1'b0, v[6:0]});
            rd_chk("R3 uctl readback", 2'd1, {1'b0, v[6:0]});
        end
        wr(2'd1, 8'h02);

        // R3 R11 sweep of the mode bits
        for (int v = 0; v < 8; v++) begin
            wr(2'd0, {v[2:0], 5'd0});
            chk("R11 mode outputs", {5'd0, cfg_uart_mode, cfg_rx_en, cfg_spi_slave},
                {5'd0, v[2:0]});
            rd_chk("R3 mode readback", 2'd0, {v[2:0], 5'd0});
        end
        wr(2'd0, 8'h80);

        // R4 error flags clear on status read, read shows them set
        pulse(4'b1000);
        rd_chk("R4 frame err shown", 2'd0, 8'h90);
        rd_chk("R4 frame err cleared by read", 2'd0, 8'h80);
        pulse(4'b0100);
        rd_chk("R4 parity err shown", 2'd0, 8'h88);
        rd_chk("R4 parity err cleared by read", 2'd0, 8'h80);
        pulse(4'b1100);
        rd_chk("R4 both errors", 2'd0, 8'h98);
        rd_chk("R4 both cleared", 2'd0, 8'h80);

        // R5 write-1 ignored, write-0 clears; R9 busy bit not writable
        wr(2'd0, 8'h9F);
        rd_chk("R5 write 1 does not set", 2'd0, 8'h80);
        pulse(4'b0001);
        rd_chk("R8 tx done set", 2'd0, 8'h82);
        rd_chk("R4 status read keeps tx done", 2'd0, 8'h82);
        wr(2'd0, 8'h82);
        rd_chk("R5 write 1 keeps tx done", 2'd0, 8'h82);
        wr(2'd0, 8'h80);
        rd_chk("R5 write 0 clears tx done", 2'd0, 8'h80);
        pulse(4'b1000);
        wr(2'd0, 8'h80);
        rd_chk("R5 write 0 clears frame err", 2'd0, 8'h80);
        pulse(4'b0100);
        wr(2'd0, 8'h80);
        rd_chk("R5 write 0 clears parity err", 2'd0, 8'h80);

        // R6 receive ready cleared by buffer read
        rx_data = 8'hA5;
        pulse(4'b0010);
        rd_chk("R6 rx ready set", 2'd0, 8'h84);
        rd_chk("R4 status read keeps rx ready", 2'd0, 8'h84);
        rd_chk("R6 buffer data", 2'd2, 8'hA5);
        rd_chk("R6 rx ready cleared by buffer read", 2'd0, 8'h80);

        // R7 discard pulse
        pulse(4'b0010);
        wr(2'd0, 8'h80);
        chk("R7 discard high", {7'd0, rx_discard}, 8'h01);
        @(negedge clk);
        chk("R7 discard one cycle", {7'd0, rx_discard}, 8'h00);
        rd_chk("R5 rx ready cleared by write 0", 2'd0, 8'h80);
        wr(2'd0, 8'h80);
        chk("R7 no discard when empty", {7'd0, rx_discard}, 8'h00);

        // R8 set beats same-cycle clear
        @(negedge clk);
        ev_frame_err = 1'b1; bus_addr = 2'd0; bus_rd = 1'b1;
        @(negedge clk);
        ev_frame_err = 1'b0; bus_rd = 1'b0;
        chk("R8 read returns pre-event value", bus_rdata, 8'h80);
        rd_chk("R8 frame err kept over read clear", 2'd0, 8'h90);
        @(negedge clk);
        ev_tx_done = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h80; bus_wr = 1'b1;
        @(negedge clk);
        ev_tx_done = 1'b0; bus_wr = 1'b0;
        chk("R8 no discard on tx collision", {7'd0, rx_discard}, 8'h00);
        rd_chk("R8 tx done kept over write 0", 2'd0, 8'h82);
        @(negedge clk);
        ev_rx_byte = 1'b1; bus_addr = 2'd2; bus_rd = 1'b1;
        @(negedge clk);
        ev_rx_byte = 1'b0; bus_rd = 1'b0;
        rd_chk("R8 rx ready kept over buffer read", 2'd0, 8'h86);
        @(negedge clk);
        ev_rx_byte = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h80; bus_wr = 1'b1;
        @(negedge clk);
        ev_rx_byte = 1'b0; bus_wr = 1'b0;
        chk("R7 no discard when new byte arrives", {7'd0, rx_discard}, 8'h00);
        wr(2'd0, 8'h80);
        rd_chk("R5 all cleared", 2'd0, 8'h80);

        // R9 busy source selection
        engine_busy = 1'b1;
        rd_chk("R9 busy in UART mode", 2'd0, 8'h81);
        wr(2'd0, 8'h20);
        rd_chk("R9 slave ignores engine busy", 2'd0, 8'h20);
        engine_busy = 1'b0; ssel_in = 1'b1;
        rd_chk("R9 slave shows select", 2'd0, 8'h21);
        wr(2'd0, 8'h01);
        rd_chk("R9 master ignores select", 2'd0, 8'h00);
        engine_busy = 1'b1;
        rd_chk("R9 master shows engine busy", 2'd0, 8'h01);
        engine_busy = 1'b0; ssel_in = 1'b0;

        // R10 flush self-clears
        wr(2'd1, 8'h82);
        chk("R10 flush high", {7'd0, flush_pulse}, 8'h01);
        @(negedge clk);
        chk("R10 flush one cycle", {7'd0, flush_pulse}, 8'h00);
        rd_chk("R10 flush reads 0", 2'd1, 8'h02);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule